// File: doc/BRIEF.md
# Triggered Transfer-Group Buffer Sequencer

The block keeps a shared table of transfer entries. Each entry holds four 16-bit words: the word to transmit, the word received, a per-word control word and a status word. Up to eight transfer groups each cover a range of entries given by a first and a last index. Each group has its own trigger source, chosen from fifteen trigger inputs, and its own event type. The event type is either a rising edge or a low level.

When a group fires, the sequencer walks that group's entries in ascending index order. For each entry it starts the external shift engine with the entry's transmit and control words. It waits for the engine's done strobe, then stores the received word and a status word in the entry. After the last entry of a group it raises a one-cycle completion pulse for that group.

Software loads entries and group settings through a write port and reads entries back through a combinational read port. Pending groups are served in fixed priority, lowest group number first. A pass that has started is never interrupted.

Top module: `tgs_top`

## Requirements
- R1: After reset, `sh_start_o` and `grp_done_o` are low, every field of every entry reads zero, and every group has source code 15 (disabled).
- R2: The field select code is 0 for transmit, 1 for receive, 2 for control and 3 for status. A host write to entry i, field f is returned by a read of entry i, field f.
- R3: In edge mode, a rising edge on the selected trigger input starts one pass over the group's entries in ascending index order. While `sh_start_o` is high, `sh_txd_o` and `sh_ctl_o` carry that entry's transmit and control words.
- R4: On `sh_done_i`, the current entry's receive field takes `sh_rxd_i`. Its status field becomes bit 0 = 1 (receive valid), bit 1 = `sh_ovr_i`, and all other bits 0. No other entry changes.
- R5: When several groups are pending in the same cycle, the lowest-numbered group runs first. A pass in progress is not interrupted by a lower-numbered group becoming pending.
- R6: In level mode, the group starts while its selected input is low and restarts from its first entry after each pass for as long as the input is low. Once the input is high at the end of a pass, no further pass starts.
- R7: `grp_done_o` has at most one bit set. Bit g pulses for exactly one cycle, one cycle after the done strobe of group g's last entry.
- R8: Source codes 0 to 14 select the matching `trig_i` bit. Code 15 never starts the group, in either mode.
- R9: `sh_start_o` is high for one cycle per entry and is not raised again before the engine's done strobe for that entry.
- R10: When the first index is greater than the last, the walk runs up to entry 127, wraps to entry 0 and continues to the last index.
- R11: A rising edge on a group's source during that group's own pass is held and causes exactly one further pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_we_i | input | 1 | Host entry write strobe |
| mem_widx_i | input | 7 | Host write entry index |
| mem_wfld_i | input | 2 | Host write field select |
| mem_wdata_i | input | 16 | Host write data |
| mem_ridx_i | input | 7 | Host read entry index |
| mem_rfld_i | input | 2 | Host read field select |
| mem_rdata_o | output | 16 | Host read data (combinational) |
| cfg_we_i | input | 1 | Group setting write strobe |
| cfg_grp_i | input | 3 | Group number to configure |
| cfg_first_i | input | 7 | First entry index of the group |
| cfg_last_i | input | 7 | Last entry index of the group |
| cfg_src_i | input | 4 | Trigger source code (15 = disabled) |
| cfg_level_i | input | 1 | 1 = low-level event, 0 = rising-edge event |
| trig_i | input | 15 | Trigger inputs |
| sh_start_o | output | 1 | Start strobe to shift engine |
| sh_txd_o | output | 16 | Word to transmit |
| sh_ctl_o | output | 16 | Format/control word for the transfer |
| sh_done_i | input | 1 | Shift engine done strobe |
| sh_rxd_i | input | 16 | Word received by shift engine |
| sh_ovr_i | input | 1 | Shift engine overrun flag |
| grp_done_o | output | 8 | Per-group completion pulse |

## Verification
The bench goes after arbitration order when two groups become pending in the same cycle. A design that picks the higher number, or rotates priority, sends the entries in the wrong order. It also raises a lower-numbered trigger in the middle of another group's pass; a preempting design would break into that pass. It re-arms an edge group while that group is running, and it releases a low-level trigger during the third pass. A design that drops the held edge, or that checks the level only once, would run too few or too many passes. Other cases are a range that wraps past entry 127 and a source code of 15 with every input toggling. A design that lets the counter run past the end of the table, or that decodes code 15 as an input, would then touch the wrong entries or start a disabled group.

// File: rtl/tgs_pkg.sv
package tgs_pkg;
  typedef enum logic [1:0] {
    FLD_TX   = 2'd0,
    FLD_RX   = 2'd1,
    FLD_CTL  = 2'd2,
    FLD_STAT = 2'd3
  } fld_e;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_ISSUE = 2'd1,
    WK_WAIT  = 2'd2
  } wk_state_e;

  localparam int unsigned STAT_RXV = 0;
  localparam int unsigned STAT_OVR = 1;
  localparam int unsigned N_FLD    = 4;
endpackage

// File: rtl/tgs_buf_mem.sv
module tgs_buf_mem
  import tgs_pkg::*;
#(
  parameter int unsigned N_ENT = 128,
  parameter int unsigned DW    = 16,
  localparam int unsigned IW   = $clog2(N_ENT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_we_i,
  input  logic [IW-1:0] host_widx_i,
  input  logic [1:0]    host_wfld_i,
  input  logic [DW-1:0] host_wdata_i,
  input  logic [IW-1:0] host_ridx_i,
  input  logic [1:0]    host_rfld_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic          seq_we_i,
  input  logic [IW-1:0] seq_idx_i,
  input  logic [DW-1:0] seq_rxd_i,
  input  logic [DW-1:0] seq_stat_i,
  output logic [DW-1:0] seq_txd_o,
  output logic [DW-1:0] seq_ctl_o
);
  logic [N_FLD-1:0][DW-1:0] host_rd;
  logic [N_FLD-1:0][DW-1:0] seq_rd;

  for (genvar f = 0; f < N_FLD; f++) begin : g_fld
    logic [DW-1:0] arr_q [N_ENT];
    logic          sq_wr;
    logic [DW-1:0] sq_dat;
    logic          hs_wr;

    if (f == int'(FLD_RX)) begin : g_rx
      assign sq_wr  = seq_we_i;
      assign sq_dat = seq_rxd_i;
    end else if (f == int'(FLD_STAT)) begin : g_st
      assign sq_wr  = seq_we_i;
      assign sq_dat = seq_stat_i;
    end else begin : g_ro
      assign sq_wr  = 1'b0;
      assign sq_dat = '0;
    end

    // sequencer write wins on a same-entry collision
    assign hs_wr = host_we_i && (host_wfld_i == 2'(f)) &&
                   !(sq_wr && (seq_idx_i == host_widx_i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < N_ENT; i++) arr_q[i] <= '0;
      end else begin
        if (sq_wr) arr_q[seq_idx_i] <= sq_dat;
        if (hs_wr) arr_q[host_widx_i] <= host_wdata_i;
      end
    end

    assign host_rd[f] = arr_q[host_ridx_i];
    assign seq_rd[f]  = arr_q[seq_idx_i];
  end

  assign host_rdata_o = host_rd[host_rfld_i];
  assign seq_txd_o    = seq_rd[FLD_TX];
  assign seq_ctl_o    = seq_rd[FLD_CTL];
endmodule

// File: rtl/tgs_trig_unit.sv
module tgs_trig_unit #(
  parameter int unsigned N_GRP  = 8,
  parameter int unsigned N_TRIG = 15,
  parameter int unsigned IW     = 7,
  localparam int unsigned GW    = (N_GRP > 1) ? $clog2(N_GRP) : 1,
  localparam int unsigned SW    = $clog2(N_TRIG + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_we_i,
  input  logic [GW-1:0]              cfg_grp_i,
  input  logic [IW-1:0]              cfg_first_i,
  input  logic [IW-1:0]              cfg_last_i,
  input  logic [SW-1:0]              cfg_src_i,
  input  logic                       cfg_level_i,
  input  logic [N_TRIG-1:0]          trig_i,
  input  logic [N_GRP-1:0]           clr_i,
  output logic [N_GRP-1:0]           req_o,
  output logic [N_GRP-1:0][IW-1:0]   first_o,
  output logic [N_GRP-1:0][IW-1:0]   last_o
);
  logic [N_TRIG-1:0] trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= '1;
    else         trig_q <= trig_i;
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic [IW-1:0] first_q, last_q;
    logic [SW-1:0] src_q;
    logic          lvl_q, pend_q;
    logic          cur, prv, valid, rise;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        first_q <= '0;
        last_q  <= '0;
        src_q   <= SW'(N_TRIG);
        lvl_q   <= 1'b0;
      end else if (cfg_we_i && cfg_grp_i == GW'(g)) begin
        first_q <= cfg_first_i;
        last_q  <= cfg_last_i;
        src_q   <= cfg_src_i;
        lvl_q   <= cfg_level_i;
      end
    end

    always_comb begin
      cur = 1'b1;
      prv = 1'b1;
      for (int t = 0; t < N_TRIG; t++) begin
        if (src_q == SW'(t)) begin
          cur = trig_i[t];
          prv = trig_q[t];
        end
      end
    end

    assign valid = (src_q < SW'(N_TRIG));
    assign rise  = valid && !lvl_q && cur && !prv;

    // new edge outranks dispatch clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_q <= 1'b0;
      else if (rise)     pend_q <= 1'b1;
      else if (clr_i[g]) pend_q <= 1'b0;
    end

    assign req_o[g]   = lvl_q ? (valid && !cur) : pend_q;
    assign first_o[g] = first_q;
    assign last_o[g]  = last_q;
  end
endmodule

// File: rtl/tgs_arbiter.sv
module tgs_arbiter #(
  parameter int unsigned N   = 8,
  localparam int unsigned GW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [GW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = GW'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/tgs_walker.sv
module tgs_walker
  import tgs_pkg::*;
#(
  parameter int unsigned N_ENT = 128,
  parameter int unsigned N_GRP = 8,
  localparam int unsigned IW   = $clog2(N_ENT),
  localparam int unsigned GW   = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_any_i,
  input  logic [N_GRP-1:0] gnt_i,
  input  logic [GW-1:0]    gnt_idx_i,
  input  logic [IW-1:0]    first_i,
  input  logic [IW-1:0]    last_i,
  input  logic             sh_done_i,
  output logic [N_GRP-1:0] clr_o,
  output logic             sh_start_o,
  output logic [IW-1:0]    idx_o,
  output logic             seq_we_o,
  output logic [N_GRP-1:0] grp_done_o
);
  wk_state_e        state_q;
  logic [IW-1:0]    idx_q, last_q, idx_nxt;
  logic [GW-1:0]    grp_q;
  logic [N_GRP-1:0] done_q;
  logic             dispatch, at_last;

  assign dispatch   = (state_q == WK_IDLE) && req_any_i;
  assign clr_o      = dispatch ? gnt_i : '0;
  assign sh_start_o = (state_q == WK_ISSUE);
  assign seq_we_o   = (state_q == WK_WAIT) && sh_done_i;
  assign at_last    = (idx_q == last_q);
  assign idx_nxt    = (idx_q == IW'(N_ENT - 1)) ? '0 : idx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WK_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      grp_q   <= '0;
      done_q  <= '0;
    end else begin
      done_q <= '0;
      unique case (state_q)
        WK_IDLE: if (dispatch) begin
          grp_q   <= gnt_idx_i;
          idx_q   <= first_i;
          last_q  <= last_i;
          state_q <= WK_ISSUE;
        end
        WK_ISSUE: state_q <= WK_WAIT;
        WK_WAIT: if (sh_done_i) begin
          if (at_last) begin
            done_q  <= N_GRP'(1) << grp_q;
            state_q <= WK_IDLE;
          end else begin
            idx_q   <= idx_nxt;
            state_q <= WK_ISSUE;
          end
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  assign idx_o      = idx_q;
  assign grp_done_o = done_q;
endmodule

// File: rtl/tgs_top.sv
module tgs_top
  import tgs_pkg::*;
#(
  parameter int unsigned N_ENT  = 128,
  parameter int unsigned N_GRP  = 8,
  parameter int unsigned N_TRIG = 15,
  parameter int unsigned DW     = 16,
  localparam int unsigned IW    = $clog2(N_ENT),
  localparam int unsigned GW    = (N_GRP > 1) ? $clog2(N_GRP) : 1,
  localparam int unsigned SW    = $clog2(N_TRIG + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_we_i,
  input  logic [IW-1:0]     mem_widx_i,
  input  logic [1:0]        mem_wfld_i,
  input  logic [DW-1:0]     mem_wdata_i,
  input  logic [IW-1:0]     mem_ridx_i,
  input  logic [1:0]        mem_rfld_i,
  output logic [DW-1:0]     mem_rdata_o,
  input  logic              cfg_we_i,
  input  logic [GW-1:0]     cfg_grp_i,
  input  logic [IW-1:0]     cfg_first_i,
  input  logic [IW-1:0]     cfg_last_i,
  input  logic [SW-1:0]     cfg_src_i,
  input  logic              cfg_level_i,
  input  logic [N_TRIG-1:0] trig_i,
  output logic              sh_start_o,
  output logic [DW-1:0]     sh_txd_o,
  output logic [DW-1:0]     sh_ctl_o,
  input  logic              sh_done_i,
  input  logic [DW-1:0]     sh_rxd_i,
  input  logic              sh_ovr_i,
  output logic [N_GRP-1:0]  grp_done_o
);
  logic [N_GRP-1:0]         req, gnt, clr;
  logic [N_GRP-1:0][IW-1:0] first_arr, last_arr;
  logic [GW-1:0]            gnt_idx;
  logic                     req_any, seq_we;
  logic [IW-1:0]            seq_idx;
  logic [DW-1:0]            stat_word;

  always_comb begin
    stat_word           = '0;
    stat_word[STAT_RXV] = 1'b1;
    stat_word[STAT_OVR] = sh_ovr_i;
  end

  tgs_trig_unit #(
    .N_GRP (N_GRP),
    .N_TRIG(N_TRIG),
    .IW    (IW)
  ) i_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_grp_i  (cfg_grp_i),
    .cfg_first_i(cfg_first_i),
    .cfg_last_i (cfg_last_i),
    .cfg_src_i  (cfg_src_i),
    .cfg_level_i(cfg_level_i),
    .trig_i     (trig_i),
    .clr_i      (clr),
    .req_o      (req),
    .first_o    (first_arr),
    .last_o     (last_arr)
  );

  tgs_arbiter #(.N(N_GRP)) i_arb (
    .req_i(req),
    .gnt_o(gnt),
    .idx_o(gnt_idx),
    .any_o(req_any)
  );

  tgs_walker #(.N_ENT(N_ENT), .N_GRP(N_GRP)) i_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_any_i (req_any),
    .gnt_i     (gnt),
    .gnt_idx_i (gnt_idx),
    .first_i   (first_arr[gnt_idx]),
    .last_i    (last_arr[gnt_idx]),
    .sh_done_i (sh_done_i),
    .clr_o     (clr),
    .sh_start_o(sh_start_o),
    .idx_o     (seq_idx),
    .seq_we_o  (seq_we),
    .grp_done_o(grp_done_o)
  );

  tgs_buf_mem #(.N_ENT(N_ENT), .DW(DW)) i_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_we_i   (mem_we_i),
    .host_widx_i (mem_widx_i),
    .host_wfld_i (mem_wfld_i),
    .host_wdata_i(mem_wdata_i),
    .host_ridx_i (mem_ridx_i),
    .host_rfld_i (mem_rfld_i),
    .host_rdata_o(mem_rdata_o),
    .seq_we_i    (seq_we),
    .seq_idx_i   (seq_idx),
    .seq_rxd_i   (sh_rxd_i),
    .seq_stat_i  (stat_word),
    .seq_txd_o   (sh_txd_o),
    .seq_ctl_o   (sh_ctl_o)
  );
endmodule

// File: rtl/tgs_checker.sv
module tgs_checker #(
  parameter int unsigned N_GRP = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sh_start_o,
  input logic             sh_done_i,
  input logic [N_GRP-1:0] grp_done_o
);
  logic out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         out_q <= 1'b0;
    else if (sh_start_o) out_q <= 1'b1;
    else if (sh_done_i)  out_q <= 1'b0;
  end

  a_r9_start_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_start_o |=> !sh_start_o);

  a_r9_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_start_o |-> !out_q);

  a_r7_done_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grp_done_o));

  a_r7_done_follows_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grp_done_o) |-> $past(sh_done_i && out_q));

  a_r7_done_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grp_done_o) |=> (grp_done_o == '0));
endmodule

bind tgs_top tgs_checker #(.N_GRP(N_GRP)) i_tgs_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sh_start_o(sh_start_o),
  .sh_done_i (sh_done_i),
  .grp_done_o(grp_done_o)
);

// File: tb/test_tgs_top.sv
`timescale 1ns/1ps
module test_tgs_top;
  localparam int N_ENT = 128;
  localparam int DLY   = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mem_we_i = 1'b0;
  logic [6:0]  mem_widx_i = '0;
  logic [1:0]  mem_wfld_i = '0;
  logic [15:0] mem_wdata_i = '0;
  logic [6:0]  mem_ridx_i = '0;
  logic [1:0]  mem_rfld_i = '0;
  logic [15:0] mem_rdata_o;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_grp_i = '0;
  logic [6:0]  cfg_first_i = '0;
  logic [6:0]  cfg_last_i = '0;
  logic [3:0]  cfg_src_i = '0;
  logic        cfg_level_i = 1'b0;
  logic [14:0] trig_i = '1;
  logic        sh_start_o;
  logic [15:0] sh_txd_o, sh_ctl_o;
  logic        sh_done_i = 1'b0;
  logic [15:0] sh_rxd_i = '0;
  logic        sh_ovr_i = 1'b0;
  logic [7:0]  grp_done_o;

  int total = 0;
  int bad = 0;
  int start_cnt = 0;
  logic [31:0] exp_q[$];
  logic [7:0]  dexp_q[$];

  always #10 clk_i = ~clk_i;

  tgs_top i_tgs_top (.*);

  function automatic logic [15:0] tx_of(int i);
    return 16'(i * 257) ^ 16'h3C5A;
  endfunction

  function automatic logic [15:0] ctl_of(int i);
    return 16'h8000 | 16'(i);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic mem_wr(input int idx, input int fld, input logic [15:0] d);
    @(negedge clk_i);
    mem_we_i = 1'b1; mem_widx_i = 7'(idx); mem_wfld_i = 2'(fld); mem_wdata_i = d;
    @(negedge clk_i);
    mem_we_i = 1'b0;
  endtask

  task automatic mem_rd(input int idx, input int fld, output logic [15:0] d);
    @(negedge clk_i);
    mem_ridx_i = 7'(idx); mem_rfld_i = 2'(fld);
    #1 d = mem_rdata_o;
  endtask

  task automatic cfg(input int g, input int first, input int last, input int src, input bit lvl);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_grp_i = 3'(g); cfg_first_i = 7'(first);
    cfg_last_i = 7'(last); cfg_src_i = 4'(src); cfg_level_i = lvl;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic pulse(input int t);
    @(negedge clk_i); trig_i[t] = 1'b0;
    repeat (2) @(negedge clk_i);
    trig_i[t] = 1'b1;
  endtask

  task automatic push_pass(input int first, input int last, input int g);
    int i = first;
    forever begin
      exp_q.push_back({ctl_of(i), tx_of(i)});
      if (i == last) break;
      i = (i + 1) % N_ENT;
    end
    dexp_q.push_back(8'(1 << g));
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while ((exp_q.size() != 0 || dexp_q.size() != 0) && n < 3000) begin
      @(negedge clk_i); n++;
    end
    repeat (10) @(negedge clk_i);
    chk(tag, 32'(exp_q.size() + dexp_q.size()), 32'd0);
  endtask

  // shift engine model and transfer scoreboard (R3, R9)
  initial begin
    logic [31:0] e;
    forever begin
      @(negedge clk_i);
      sh_done_i = 1'b0;
      if (rst_ni && sh_start_o) begin
        start_cnt++;
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R3 unexpected transfer act=%h exp=none", sh_txd_o);
        end else begin
          e = exp_q.pop_front();
          chk("R3 tx word", 32'(sh_txd_o), 32'(e[15:0]));
          chk("R3 ctl word", 32'(sh_ctl_o), 32'(e[31:16]));
        end
        for (int k = 0; k < DLY; k++) begin
          @(negedge clk_i);
          chk("R9 start while outstanding", 32'(sh_start_o), 32'd0);
        end
        sh_rxd_i  = sh_txd_o ^ 16'hA5A5;
        sh_ovr_i  = sh_txd_o[0];
        sh_done_i = 1'b1;
      end
    end
  end

  // completion pulse scoreboard (R7)
  always @(negedge clk_i) begin
    if (rst_ni && grp_done_o != '0) begin
      if (dexp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R7 unexpected done act=%h exp=none", grp_done_o);
      end else begin
        chk("R7 done pulse", 32'(grp_done_o), 32'(dexp_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    int base;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 start idle", 32'(sh_start_o), 32'd0);
    chk("R1 done idle", 32'(grp_done_o), 32'd0);
    for (int f = 0; f < 4; f++) begin
      mem_rd(0, f, d);   chk("R1 entry 0 zero", 32'(d), 32'd0);
      mem_rd(127, f, d); chk("R1 entry 127 zero", 32'(d), 32'd0);
    end

    // R2 field map
    for (int i = 0; i < N_ENT; i++) begin
      mem_wr(i, 0, tx_of(i));
      mem_wr(i, 2, ctl_of(i));
    end
    mem_rd(5, 0, d);  chk("R2 tx readback", 32'(d), 32'(tx_of(5)));
    mem_rd(77, 2, d); chk("R2 ctl readback", 32'(d), 32'(ctl_of(77)));
    mem_wr(100, 1, 16'hBEEF);
    mem_rd(100, 1, d); chk("R2 rx field readback", 32'(d), 32'h0000BEEF);
    mem_wr(100, 3, 16'h0F0F);
    mem_rd(100, 3, d); chk("R2 status field readback", 32'(d), 32'h00000F0F);

    // R8 disabled source, edge and level
    cfg(6, 50, 50, 15, 1'b1);
    cfg(7, 51, 51, 15, 1'b0);
    base = start_cnt;
    pulse(4); pulse(5); pulse(14);
    @(negedge clk_i); trig_i = '0;
    repeat (5) @(negedge clk_i);
    trig_i = '1;
    repeat (20) @(negedge clk_i);
    chk("R8 code 15 never starts", 32'(start_cnt - base), 32'd0);

    // R3/R4 single edge pass
    cfg(0, 2, 5, 3, 1'b0);
    push_pass(2, 5, 0);
    pulse(3);
    wait_idle("R3 edge pass complete");
    for (int i = 2; i <= 5; i++) begin
      mem_rd(i, 1, d); chk("R4 rx stored", 32'(d), 32'(tx_of(i) ^ 16'hA5A5));
      mem_rd(i, 3, d); chk("R4 status word", 32'(d), 32'({tx_of(i)[0], 1'b1}));
    end
    mem_rd(6, 1, d); chk("R4 neighbour rx untouched", 32'(d), 32'd0);
    mem_rd(1, 3, d); chk("R4 neighbour status untouched", 32'(d), 32'd0);

    // R5 simultaneous pending
    cfg(1, 10, 11, 4, 1'b0);
    cfg(2, 20, 21, 6, 1'b0);
    push_pass(10, 11, 1);
    push_pass(20, 21, 2);
    @(negedge clk_i); trig_i[4] = 1'b0; trig_i[6] = 1'b0;
    repeat (2) @(negedge clk_i);
    trig_i[4] = 1'b1; trig_i[6] = 1'b1;
    wait_idle("R5 lowest group first");

    // R5 no preemption
    cfg(3, 30, 33, 7, 1'b0);
    push_pass(30, 33, 3);
    push_pass(10, 11, 1);
    base = start_cnt;
    pulse(7);
    while (start_cnt == base) @(negedge clk_i);
    pulse(4);
    wait_idle("R5 pass not preempted");

    // R11 re-arm during own pass
    push_pass(2, 5, 0);
    push_pass(2, 5, 0);
    base = start_cnt;
    pulse(3);
    while (start_cnt == base) @(negedge clk_i);
    pulse(3);
    wait_idle("R11 held edge gives one more pass");
    chk("R11 transfer count", 32'(start_cnt - base), 32'd8);

    // R6 level mode, released during third pass
    cfg(4, 40, 41, 8, 1'b1);
    repeat (5) @(negedge clk_i);
    chk("R6 high level idle", 32'(start_cnt), 32'(base + 8));
    push_pass(40, 41, 4);
    push_pass(40, 41, 4);
    push_pass(40, 41, 4);
    base = start_cnt;
    @(negedge clk_i); trig_i[8] = 1'b0;
    while (start_cnt < base + 5) @(negedge clk_i);
    trig_i[8] = 1'b1;
    wait_idle("R6 level repeats while low");
    chk("R6 stops after release", 32'(start_cnt - base), 32'd6);

    // R10 wrap past last entry
    cfg(5, 126, 1, 9, 1'b0);
    push_pass(126, 1, 5);
    pulse(9);
    wait_idle("R10 wrap walk");
    mem_rd(127, 1, d); chk("R10 entry 127 rx", 32'(d), 32'(tx_of(127) ^ 16'hA5A5));
    mem_rd(0, 3, d);   chk("R10 entry 0 status", 32'(d), 32'({tx_of(0)[0], 1'b1}));
    mem_rd(125, 3, d); chk("R10 entry 125 untouched", 32'(d), 32'd0);

    summary();
    $finish;
  end
endmodule